// File: doc/BRIEF.md
# Codec-side serial input frame generator

This block is the transmit half of the codec end of a serial audio link. It works from the link's bit clock. It watches a frame-sync line that the controller drives on rising bit-clock edges. When it sees a new sync pulse, it shifts one tagged 256-bit frame onto its serial output. Every output bit changes on a rising edge, so the controller can take it on the falling edge that follows.

The frame layout is fixed:

- A 16-bit header slot carries a ready flag and one valid tag per following slot.
- A status slot echoes the register index that the controller asked for.
- A status data slot carries the read data supplied by the register file.
- Two capture slots carry the left and right samples.
- The eight slots after that are sent as zero.

The status slot also carries two active-low "send me a sample" flags, one per playback channel. A per-channel phase accumulator, stepped once per frame by the programmed playback rate, paces these flags. When variable-rate mode is off, both flags are held low.

Top module: `sfg_frame_tx`

## Requirements
- R1: A rising edge of `frame_sync` is registered on the next falling clock edge. The first frame bit then appears on `sdata_out` at the rising edge after that falling edge. This first bit is the value of `codec_ready`, captured at that rising edge.
- R2: A frame is 256 bits, sent most significant bit first: a 16-bit header, then twelve 20-bit slots. Before the first frame after reset, and after the last bit of a frame, `sdata_out` is 0 until the next frame starts.
- R3: The header layout is as follows. Bit 15 is the ready flag. Bits 14 and 13 are the tags of the status slot and the status data slot, and both equal `stat_valid`. Bits 12 and 11 are the tags of the left and right capture slots, and equal `cap_valid[0]` and `cap_valid[1]`. Bits 10 to 0 are 0.
- R4: The status slot (slot 1) is laid out as follows. Bit 19 is 0. Bits 18 to 12 hold `stat_index` when `stat_valid` is 1, and are 0 when it is 0. Bits 9 to 0 are 0.
- R5: Slot 2 carries `stat_data` in bits 19 to 4, with bits 3 to 0 at 0. The whole slot is 0 when `stat_valid` is 0.
- R6: Slots 3 and 4 carry `cap_sample[0]` and `cap_sample[1]` (20 bits each) when the matching `cap_valid` bit is 1, and are 0 otherwise. Slots 5 to 12 are always 0.
- R7: While `vra_en` is 0 at a frame start, status-slot bits 11 (left) and 10 (right) are both 0, and both accumulators are cleared.
- R8: While `vra_en` is 1, each frame start adds `play_rate[ch]` to that channel's accumulator.
  - If the sum reaches 48000, 48000 is subtracted and the channel's flag is sent as 0 (request).
  - Otherwise the flag is sent as 1.
  - A rate of 48000 or more requests every frame and leaves the accumulator unchanged.
- R9: The echoed index is returned unchanged for every 7-bit value, including indexes with no register behind them.
- R10: A new rising edge of `frame_sync` during a frame abandons it and starts a new frame at once. Holding `frame_sync` high starts nothing further.
- R11: All frame fields are captured at the frame start. Changing the inputs during a frame does not alter the bits still to be sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | Frame sync from the controller, changes on rising edges |
| codec_ready | input | 1 | Ready flag placed in header bit 15 |
| stat_valid | input | 1 | A status reply is due in this frame |
| stat_index | input | 7 | Register index to echo in the status slot |
| stat_data | input | 16 | Read data for the echoed index |
| vra_en | input | 1 | Variable-rate mode enable |
| play_rate | input | 2x16 | Programmed playback rate per channel, in Hz |
| cap_valid | input | 2 | Capture sample valid, per channel |
| cap_sample | input | 2x20 | Capture samples, index 0 left, index 1 right |
| sdata_out | output | 1 | Serial frame output |

## Verification
A restart can land on the same rising edge that shifts out a bit of the frame still in progress. The bench provokes this by raising sync again after 100 bits. It then expects the abandoned frame's bit 100 on the falling edge just before the restart, and the new frame's ready bit one edge later.

The request flags and the index echo share one slot, so each frame start captures both together. The reference model recomputes both from its own accumulators at every start. This includes starts that cut a frame short, and the frame after variable-rate mode is switched off and back on. The model compares all 20 bits of that slot on every falling edge.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
    // Fixed frame format shared by packer, top and checker.
    localparam int TAG_W      = 16;
    localparam int SLOT_W     = 20;
    localparam int NSLOT      = 12;
    localparam int FRAME_BITS = TAG_W + NSLOT * SLOT_W;
endpackage

// File: rtl/sfg_sync_edge.sv
// Samples frame sync on falling clock edges and flags a fresh low-to-high step.
module sfg_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic start
);
    typedef struct packed {
        logic cur;
        logic prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.cur  = sync_in;
        s_d.prev = s_q.cur;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R1 / R10: only a 0 -> 1 step between two falling edges starts a frame.
    assign start = s_q.cur & ~s_q.prev;
endmodule

// File: rtl/sfg_rate_pacer.sv
// Per-channel phase accumulator producing the active-low sample request flag.
module sfg_rate_pacer #(
    parameter int RATE_W    = 16,
    parameter int BASE_RATE = 48000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              vra_en,
    input  logic [RATE_W-1:0] rate,
    output logic              req_n
);
    localparam int ACC_W = RATE_W + 1;
    localparam logic [ACC_W-1:0] BASE_C = ACC_W'(BASE_RATE);

    logic [ACC_W-1:0] acc_d, acc_q;
    logic [ACC_W-1:0] sum, acc_next;
    logic             req;

    always_comb begin
        sum      = acc_q + ACC_W'(rate);
        req      = 1'b0;
        acc_next = sum;
        if (ACC_W'(rate) >= BASE_C) begin
            // R8: full-rate or faster asks every frame, phase frozen
            req      = 1'b1;
            acc_next = acc_q;
        end else if (sum >= BASE_C) begin
            req      = 1'b1;
            acc_next = sum - BASE_C;
        end
        if (!vra_en) begin
            // R7: fixed-rate mode clears the phase
            acc_next = '0;
        end
        req_n = vra_en ? ~req : 1'b0;
        acc_d = step ? acc_next : acc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end
endmodule

// File: rtl/sfg_frame_pack.sv
// Assembles the full frame image from the fields captured at frame start.
module sfg_frame_pack
    import sfg_pkg::*;
#(
    parameter int IDX_W  = 7,
    parameter int STAT_W = 16,
    parameter int SAMP_W = 20,
    parameter int NCH    = 2
) (
    input  logic                          ready,
    input  logic                          stat_valid,
    input  logic [IDX_W-1:0]              stat_index,
    input  logic [STAT_W-1:0]             stat_data,
    input  logic [NCH-1:0]                cap_valid,
    input  logic [NCH-1:0][SAMP_W-1:0]    cap_sample,
    input  logic [NCH-1:0]                req_n,
    output logic [FRAME_BITS-1:0]         frame
);
    localparam int FLAG_TOP = SLOT_W - 2 - IDX_W;

    logic [NSLOT-1:0]  tag;
    logic [SLOT_W-1:0] word [NSLOT];
    logic [TAG_W-1:0]  head;

    always_comb begin
        tag    = '0;
        tag[0] = stat_valid;
        tag[1] = stat_valid;
        for (int ch = 0; ch < NCH; ch++) tag[2+ch] = cap_valid[ch];

        for (int k = 0; k < NSLOT; k++) word[k] = '0;

        // R4 / R9: index echoed as received, zero when untagged
        if (stat_valid) word[0][SLOT_W-2 -: IDX_W] = stat_index;
        // R7 / R8: request flags, left in the higher bit
        for (int ch = 0; ch < NCH; ch++) word[0][FLAG_TOP-ch] = req_n[ch];
        // R5
        if (stat_valid) word[1][SLOT_W-1 -: STAT_W] = stat_data;
        // R6
        for (int ch = 0; ch < NCH; ch++) begin
            if (cap_valid[ch]) word[2+ch][SLOT_W-1 -: SAMP_W] = cap_sample[ch];
        end

        // R3
        head          = '0;
        head[TAG_W-1] = ready;
        for (int k = 0; k < NSLOT; k++) head[TAG_W-2-k] = tag[k];

        frame = '0;
        frame[FRAME_BITS-1 -: TAG_W] = head;
        for (int k = 0; k < NSLOT; k++) frame[FRAME_BITS-1-TAG_W-k*SLOT_W -: SLOT_W] = word[k];
    end
endmodule

// File: rtl/sfg_frame_tx.sv
// Top: serial input frame generator on the codec side of the link.
module sfg_frame_tx
    import sfg_pkg::*;
#(
    parameter int IDX_W     = 7,
    parameter int STAT_W    = 16,
    parameter int SAMP_W    = 20,
    parameter int RATE_W    = 16,
    parameter int NCH       = 2,
    parameter int BASE_RATE = 48000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_sync,
    input  logic                       codec_ready,
    input  logic                       stat_valid,
    input  logic [IDX_W-1:0]           stat_index,
    input  logic [STAT_W-1:0]          stat_data,
    input  logic                       vra_en,
    input  logic [NCH-1:0][RATE_W-1:0] play_rate,
    input  logic [NCH-1:0]             cap_valid,
    input  logic [NCH-1:0][SAMP_W-1:0] cap_sample,
    output logic                       sdata_out
);
    typedef struct packed {
        logic                  sdata;
        logic [FRAME_BITS-2:0] rest;
    } tx_t;

    logic                  start;
    logic [NCH-1:0]        req_n;
    logic [FRAME_BITS-1:0] frame;
    tx_t                   st_d, st_q;

    sfg_sync_edge u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (frame_sync),
        .start   (start)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_pace
        sfg_rate_pacer #(
            .RATE_W    (RATE_W),
            .BASE_RATE (BASE_RATE)
        ) u_pace (
            .clk    (clk),
            .rst_n  (rst_n),
            .step   (start),
            .vra_en (vra_en),
            .rate   (play_rate[ch]),
            .req_n  (req_n[ch])
        );
    end

    sfg_frame_pack #(
        .IDX_W  (IDX_W),
        .STAT_W (STAT_W),
        .SAMP_W (SAMP_W),
        .NCH    (NCH)
    ) u_pack (
        .ready      (codec_ready),
        .stat_valid (stat_valid),
        .stat_index (stat_index),
        .stat_data  (stat_data),
        .cap_valid  (cap_valid),
        .cap_sample (cap_sample),
        .req_n      (req_n),
        .frame      (frame)
    );

    always_comb begin
        if (start) begin
            // R1 / R10 / R11: load the snapshot, first bit out now
            {st_d.sdata, st_d.rest} = frame;
        end else begin
            // R2: shift MSB first, zeros follow the last bit
            st_d.sdata = st_q.rest[FRAME_BITS-2];
            st_d.rest  = {st_q.rest[FRAME_BITS-3:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdata_out = st_q.sdata;
endmodule

// File: rtl/sfg_frame_tx_chk.sv
// Protocol checker, bound to the top module.
module sfg_frame_tx_chk #(
    parameter int FRAME_BITS = 256,
    parameter int TAG_W      = 16,
    parameter int NCH        = 2
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic sdata,
    input logic codec_ready,
    input logic vra_en
);
    localparam int PW = $clog2(FRAME_BITS + 1);
    localparam int ZERO_TAG = 3 + NCH;
    localparam int FLAG_L   = TAG_W + 8;
    localparam int PAD_LO   = TAG_W + 10;
    localparam int PAD_HI   = TAG_W + 19;

    logic [PW-1:0] pos;
    logic          vra_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos      <= PW'(FRAME_BITS);
            vra_seen <= 1'b0;
        end else if (start) begin
            pos      <= '0;
            vra_seen <= vra_en;
        end else if (pos != PW'(FRAME_BITS)) begin
            pos <= pos + 1'b1;
        end
    end

    a_r1_ready_first: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (sdata == $past(codec_ready)));

    a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == PW'(FRAME_BITS)) |-> !sdata);

    a_r3_header_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (pos >= PW'(ZERO_TAG) && pos < PW'(TAG_W)) |-> !sdata);

    a_r4_status_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == PW'(TAG_W)) |-> !sdata);

    a_r4_status_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (pos >= PW'(PAD_LO) && pos <= PW'(PAD_HI)) |-> !sdata);

    a_r7_flags_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((pos == PW'(FLAG_L) || pos == PW'(FLAG_L + 1)) && !vra_seen) |-> !sdata);
endmodule

bind sfg_frame_tx sfg_frame_tx_chk #(
    .FRAME_BITS (sfg_pkg::FRAME_BITS),
    .TAG_W      (sfg_pkg::TAG_W),
    .NCH        (NCH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .sdata       (sdata_out),
    .codec_ready (codec_ready),
    .vra_en      (vra_en)
);

// File: tb/sfg_frame_tx_test.sv
module sfg_frame_tx_test;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_sync = 1'b0;
    logic             codec_ready;
    logic             stat_valid;
    logic [6:0]       stat_index;
    logic [15:0]      stat_data;
    logic             vra_en;
    logic [1:0][15:0] play_rate;
    logic [1:0]       cap_valid;
    logic [1:0][19:0] cap_sample;
    logic             sdata_out;

    int n_cmp = 0;
    int n_bad = 0;
    int acc [2];
    bit exp_q [$];
    bit tail_exp = 1'b0;
    bit vra_snap = 1'b0;
    bit scr_now = 1'b0;
    bit done = 1'b0;

    sfg_frame_tx uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_sync  (frame_sync),
        .codec_ready (codec_ready),
        .stat_valid  (stat_valid),
        .stat_index  (stat_index),
        .stat_data   (stat_data),
        .vra_en      (vra_en),
        .play_rate   (play_rate),
        .cap_valid   (cap_valid),
        .cap_sample  (cap_sample),
        .sdata_out   (sdata_out)
    );

    always #5ns clk = ~clk;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic check(input logic act, input logic exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: sdata_out=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push(input logic [31:0] v, input int w);
        for (int b = w - 1; b >= 0; b--) exp_q.push_back(v[b]);
    endtask

    function automatic string tag_of(input int p);
        string s;
        if (p == 0)                 s = "R1";
        else if (p < 16)            s = "R3";
        else if (p >= 17 && p < 24) s = "R4/R9";
        else if (p == 24 || p == 25) s = vra_snap ? "R8" : "R7";
        else if (p < 36)            s = "R4";
        else if (p < 56)            s = "R5";
        else                        s = "R6";
        if (scr_now && p > 40) s = {s, "/R11"};
        return s;
    endfunction

    // Reference model: runs at each frame start, from the inputs held then.
    task automatic build_expected();
        bit fl [2];
        vra_snap = vra_en;
        for (int ch = 0; ch < 2; ch++) begin
            int r = int'(play_rate[ch]);
            if (!vra_en) begin
                acc[ch] = 0;
                fl[ch]  = 1'b0;
            end else if (r >= 48000) begin
                fl[ch] = 1'b0;
            end else begin
                acc[ch] += r;
                if (acc[ch] >= 48000) begin
                    acc[ch] -= 48000;
                    fl[ch] = 1'b0;
                end else begin
                    fl[ch] = 1'b1;
                end
            end
        end
        exp_q.delete();
        push(32'(codec_ready), 1);
        push(32'(stat_valid), 1);
        push(32'(stat_valid), 1);
        push(32'(cap_valid[0]), 1);
        push(32'(cap_valid[1]), 1);
        push(0, 11);
        push(0, 1);
        push(stat_valid ? 32'(stat_index) : 0, 7);
        push(32'(fl[0]), 1);
        push(32'(fl[1]), 1);
        push(0, 10);
        push(stat_valid ? 32'(stat_data) : 0, 16);
        push(0, 4);
        push(cap_valid[0] ? 32'(cap_sample[0]) : 0, 20);
        push(cap_valid[1] ? 32'(cap_sample[1]) : 0, 20);
        for (int k = 0; k < 8; k++) push(0, 20);
    endtask

    task automatic setup(input bit rdy, input bit sv, input logic [6:0] idx,
                         input logic [15:0] dat, input bit vra, input int r0,
                         input int r1, input logic [1:0] cv,
                         input logic [19:0] s0, input logic [19:0] s1);
        codec_ready   = rdy;
        stat_valid    = sv;
        stat_index    = idx;
        stat_data     = dat;
        vra_en        = vra;
        play_rate[0]  = 16'(r0);
        play_rate[1]  = 16'(r1);
        cap_valid     = cv;
        cap_sample[0] = s0;
        cap_sample[1] = s1;
    endtask

    task automatic scramble();
        codec_ready   = 1'($urandom);
        stat_valid    = 1'($urandom);
        stat_index    = 7'($urandom);
        stat_data     = 16'($urandom);
        vra_en        = 1'($urandom);
        play_rate[0]  = 16'($urandom);
        play_rate[1]  = 16'($urandom);
        cap_valid     = 2'($urandom);
        cap_sample[0] = 20'($urandom);
        cap_sample[1] = 20'($urandom);
    endtask

    // Raise sync after a rising edge, then compare nbits on falling edges.
    task automatic run_frame(input int nbits, input bit hold, input bit scr);
        @(posedge clk);
        #1ns frame_sync = 1'b1;
        build_expected();
        scr_now = scr;
        @(negedge clk);
        check(sdata_out, tail_exp, "R2/R10 line before first bit");
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            check(sdata_out, exp_q[i], tag_of(i));
            if (scr && i == 40) scramble();
            if (i == 15 && !hold) begin
                @(posedge clk);
                #1ns frame_sync = 1'b0;
            end
        end
        tail_exp = (nbits < 256) ? exp_q[nbits] : 1'b0;
        if (hold) begin
            @(posedge clk);
            #1ns frame_sync = 1'b0;
            @(negedge clk);
            check(sdata_out, 1'b0, "R10 held sync gives no restart");
            tail_exp = 1'b0;
        end
        scr_now = 1'b0;
    endtask

    initial begin
        acc[0] = 0;
        acc[1] = 0;
        setup(1, 1, 7'h05, 16'hA5C3, 0, 44100, 8000, 2'b11, 20'hABCDE, 20'h13579);
        repeat (3) @(posedge clk);
        #1ns rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(sdata_out, 1'b0, "R2 idle after reset");
        end

        // Fixed-rate frames, full and partial tagging
        run_frame(256, 0, 0);
        setup(0, 0, 7'h7F, 16'hFFFF, 0, 44100, 8000, 2'b01, 20'hFFFFF, 20'h55555);
        run_frame(256, 0, 1);

        // R9: a spread of index values
        for (int k = 0; k < 5; k++) begin
            logic [6:0] ix;
            case (k)
                0: ix = 7'h7F;
                1: ix = 7'h00;
                2: ix = 7'h2A;
                3: ix = 7'h55;
                default: ix = 7'h6B;
            endcase
            setup(1, 1, ix, 16'(16'h1234 + k * 16'h0F0F), 0, 0, 0, 2'b10, 20'h0, 20'(k + 1));
            run_frame(256, 0, k[0]);
        end

        // R8: variable-rate pacing
        for (int k = 0; k < 14; k++) begin
            setup(1, 1, 7'(k), 16'(k * 3), 1, 44100, 8000, 2'b11, 20'(k * 77), 20'hC0FFE);
            run_frame(256, 0, k[0]);
        end
        for (int k = 0; k < 3; k++) begin
            setup(1, 0, 7'h11, 16'h0, 1, 48000, 0, 2'b00, 20'h0, 20'h0);
            run_frame(256, 0, 0);
        end
        for (int k = 0; k < 4; k++) begin
            setup(1, 1, 7'h22, 16'hBEEF, 1, 47999, 24000, 2'b11, 20'h12345, 20'h6789A);
            run_frame(256, 0, 0);
        end

        // R10: restart mid-frame, then held sync
        setup(1, 1, 7'h3C, 16'h8001, 1, 32000, 11025, 2'b11, 20'hAAAAA, 20'h55555);
        run_frame(100, 0, 0);
        run_frame(256, 0, 0);
        run_frame(256, 1, 0);
        run_frame(256, 0, 0);

        // R7 then R8: switching the mode off clears the phase
        setup(1, 1, 7'h01, 16'h0002, 0, 24000, 24000, 2'b11, 20'h1, 20'h2);
        run_frame(256, 0, 0);
        setup(1, 1, 7'h01, 16'h0002, 1, 24000, 24000, 2'b11, 20'h1, 20'h2);
        run_frame(256, 0, 0);
        run_frame(256, 0, 0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            summary();
            $finish;
        end
    end
endmodule